// File: doc/BRIEF.md
# Interrupt Acknowledge Bridge

This block connects a processor's memory-mapped interrupt window to an older 8259-style interrupt controller. That controller cannot send a vectored interrupt message, so the vector has to be fetched with an acknowledge handshake. When software does a one-byte load from the acknowledge byte, the bridge drives the acknowledge strobe toward the controller. It takes the vector the controller places on its data pins and returns that vector as the load data. Some controllers need two acknowledge cycles. For these the bridge runs both cycles for a single load, discards the data from the first cycle and returns the data from the second. The requester never sees the extra cycle.

Any other kind of access to the acknowledge byte is undefined. Such an access completes at once with an error, starts no handshake and sets a sticky status bit. A one-byte store to the task-priority byte loads an external task priority register and pulses an update strobe for that register.

Requests enter over a valid/ready channel, and responses leave over a second valid/ready channel. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A response is consumed on an edge where `rsp_valid` and `rsp_ready` are both high. Only one access can be in flight at a time. `req_ready` stays low from acceptance until the response has been consumed. While `rsp_ready` is low, the response stays on the pins without change.

Top module: `intack_bridge`

## Requirements
- R1: After reset, `req_ready` is 1, and `rsp_valid`, `ack_strobe`, `tpr_update`, `undef_flag` and `tpr_value` are all 0.
- R2: The acknowledge byte sits at address BASE + 0x1E0000. An acknowledge handshake starts only for a load (`req_write`=0) of size code 0 (one byte) that matches this address exactly. Size codes are 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes and 3 = 8 bytes.
- R3: In single mode (`dbl_mode`=0 at acceptance), `ack_strobe` is high for PULSE_CLKS consecutive cycles. The response carries the vector that `ctl_vector` shows in the last strobe cycle, with `rsp_err`=0. The response is valid PULSE_CLKS+1 cycles after the accepting edge.
- R4: In double mode (`dbl_mode`=1 at acceptance), the bridge drives two strobe pulses of PULSE_CLKS cycles each, with GAP_CLKS idle cycles (at least 1) between them. Controller data during the first pulse is ignored. The vector from the last cycle of the second pulse is returned. The response is valid 2*PULSE_CLKS+GAP_CLKS+1 cycles after acceptance.
- R5: A store of any size, or a load of size code 1 to 3, to the acknowledge byte is undefined. Its response is valid one cycle after acceptance with `rsp_err`=1 and data 0x00. No strobe is driven, and `undef_flag` goes to 1 and stays there until reset.
- R6: A one-byte store to the task-priority address (BASE + TPR_OFS) makes `tpr_value` equal to `req_wdata`, and pulses `tpr_update` for one cycle, in the cycle after acceptance. Stores of other sizes, and loads, leave `tpr_value` unchanged. These accesses respond one cycle after acceptance with data 0x00 and `rsp_err`=0.
- R7: `req_ready` is 0 from the accepting edge until the response has been consumed, so at most one access is outstanding.
- R8: While `rsp_valid`=1 and `rsp_ready`=0, `rsp_valid`, `rsp_data` and `rsp_err` hold their values. `rsp_valid` drops in the cycle after the consuming edge.
- R9: An access to any other address responds one cycle after acceptance with data 0x00 and `rsp_err`=0, and drives no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request is valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_addr | input | ADDR_W | Byte address of the request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_size | input | 2 | Size code: 0 = 1, 1 = 2, 2 = 4, 3 = 8 bytes |
| req_wdata | input | 8 | Store data byte |
| rsp_valid | output | 1 | Response is valid |
| rsp_ready | input | 1 | Requester takes the response |
| rsp_data | output | 8 | Load data (the vector for acknowledge loads) |
| rsp_err | output | 1 | Access was undefined |
| dbl_mode | input | 1 | 1 = two acknowledge cycles per load |
| ack_strobe | output | 1 | Acknowledge strobe to the controller |
| ctl_vector | input | 8 | Data driven by the controller |
| tpr_value | output | 8 | External task priority register |
| tpr_update | output | 1 | One-cycle pulse when the task priority register is written |
| undef_flag | output | 1 | Sticky flag: an undefined access has occurred |

## Verification
The bench counts negative clock edges from the accepting edge and compares the first edge where `rsp_valid` is high against the due cycle. That cycle is one edge later for undefined, task-priority and non-decoded accesses, PULSE_CLKS+1 edges later in single mode, and 2*PULSE_CLKS+GAP_CLKS+1 edges later in double mode. While waiting, it counts the high strobe cycles and the rising edges of the strobe, and checks that `req_ready` stays low. The task-priority register and its update pulse are checked on the first negative edge after acceptance. The response is then held under back-pressure for two cycles, checked for stability, and checked to drop one edge after it is consumed.

// File: rtl/intack_pkg.sv
package intack_pkg;
  typedef enum logic [1:0] {
    ACC_OTHER = 2'd0,
    ACC_ACK   = 2'd1,
    ACC_UNDEF = 2'd2,
    ACC_TPR   = 2'd3
  } acc_kind_e;

  localparam logic [1:0] SIZE_BYTE = 2'd0;
  localparam logic [31:0] ACK_OFFSET = 32'h001E_0000;
endpackage

// File: rtl/intack_decode.sv
module intack_decode
  import intack_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hFE00_0000,
  parameter logic [ADDR_W-1:0] TPR_OFS = 32'h001E_0008
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [1:0]        size,
  output acc_kind_e         kind,
  output logic              tpr_wr
);
  localparam logic [ADDR_W-1:0] ACK_ADDR = BASE + ADDR_W'(ACK_OFFSET);
  localparam logic [ADDR_W-1:0] TPR_ADDR = BASE + TPR_OFS;

  logic hit_ack, hit_tpr, one_byte;

  always_comb begin
    hit_ack  = (addr == ACK_ADDR);
    hit_tpr  = (addr == TPR_ADDR);
    one_byte = (size == SIZE_BYTE);
    tpr_wr   = hit_tpr && write && one_byte;
    if (hit_ack)      kind = (!write && one_byte) ? ACC_ACK : ACC_UNDEF;
    else if (hit_tpr) kind = ACC_TPR;
    else              kind = ACC_OTHER;
  end
endmodule

// File: rtl/intack_seq.sv
module intack_seq #(
  parameter int PULSE_CLKS = 2,
  parameter int GAP_CLKS = 1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic       dbl,
  input  logic [7:0] ctl_vector,
  output logic       strobe,
  output logic       busy,
  output logic       done,
  output logic [7:0] vec
);
  localparam int MAXC = (PULSE_CLKS > GAP_CLKS) ? PULSE_CLKS : GAP_CLKS;
  localparam int CW = $clog2(MAXC + 1);
  localparam logic [CW-1:0] P_LAST = CW'(PULSE_CLKS - 1);
  localparam logic [CW-1:0] G_LAST = CW'(GAP_CLKS - 1);

  typedef enum logic [1:0] {S_IDLE, S_PULSE, S_GAP} seq_state_e;

  seq_state_e state;
  logic [CW-1:0] cnt;
  logic final_pulse;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      final_pulse <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state       <= S_PULSE;
          cnt         <= '0;
          final_pulse <= !dbl;
        end
        S_PULSE: if (cnt == P_LAST) begin
          cnt   <= '0;
          state <= final_pulse ? S_IDLE : S_GAP;
        end else begin
          cnt <= cnt + 1'b1;
        end
        S_GAP: if (cnt == G_LAST) begin
          cnt         <= '0;
          state       <= S_PULSE;
          final_pulse <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe = (state == S_PULSE);
    busy   = (state != S_IDLE);
    done   = strobe && final_pulse && (cnt == P_LAST);
    vec    = ctl_vector;
  end
endmodule

// File: rtl/intack_tpr.sv
module intack_tpr #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] value,
  output logic              update
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      value  <= '0;
      update <= 1'b0;
    end else begin
      update <= wr_en;
      if (wr_en) value <= wr_data;
    end
  end
endmodule

// File: rtl/intack_bridge.sv
module intack_bridge
  import intack_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] BASE = 32'hFE00_0000,
  parameter logic [ADDR_W-1:0] TPR_OFS = 32'h001E_0008,
  parameter int PULSE_CLKS = 2,
  parameter int GAP_CLKS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_size,
  input  logic [7:0]        req_wdata,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [7:0]        rsp_data,
  output logic              rsp_err,
  input  logic              dbl_mode,
  output logic              ack_strobe,
  input  logic [7:0]        ctl_vector,
  output logic [7:0]        tpr_value,
  output logic              tpr_update,
  output logic              undef_flag
);
  acc_kind_e kind;
  logic tpr_wr, accept, seq_busy, seq_done;
  logic [7:0] seq_vec;

  intack_decode #(.ADDR_W(ADDR_W), .BASE(BASE), .TPR_OFS(TPR_OFS)) dec_i (
    .addr(req_addr), .write(req_write), .size(req_size),
    .kind(kind), .tpr_wr(tpr_wr)
  );

  assign req_ready = !seq_busy && !rsp_valid;
  assign accept    = req_valid && req_ready;

  intack_seq #(.PULSE_CLKS(PULSE_CLKS), .GAP_CLKS(GAP_CLKS)) seq_i (
    .clk(clk), .rst_n(rst_n),
    .start(accept && (kind == ACC_ACK)), .dbl(dbl_mode),
    .ctl_vector(ctl_vector), .strobe(ack_strobe), .busy(seq_busy),
    .done(seq_done), .vec(seq_vec)
  );

  intack_tpr #(.DATA_W(8)) tpr_i (
    .clk(clk), .rst_n(rst_n), .wr_en(accept && tpr_wr),
    .wr_data(req_wdata), .value(tpr_value), .update(tpr_update)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_data   <= '0;
      rsp_err    <= 1'b0;
      undef_flag <= 1'b0;
    end else if (seq_done) begin
      rsp_valid <= 1'b1;
      rsp_data  <= seq_vec;
      rsp_err   <= 1'b0;
    end else if (accept && (kind != ACC_ACK)) begin
      rsp_valid <= 1'b1;
      rsp_data  <= '0;
      rsp_err   <= (kind == ACC_UNDEF);
      if (kind == ACC_UNDEF) undef_flag <= 1'b1;
    end else if (rsp_valid && rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end
endmodule

module intack_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_ready,
  input logic       req_write,
  input logic       rsp_valid,
  input logic       rsp_ready,
  input logic [7:0] rsp_data,
  input logic       rsp_err,
  input logic       ack_strobe,
  input logic [7:0] tpr_value,
  input logic       undef_flag
);
  a_r7_no_accept_while_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  a_r7_no_accept_while_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    ack_strobe |-> !req_ready);
  a_r8_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));
  a_r5_err_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> (rsp_data == 8'h00));
  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    undef_flag |=> undef_flag);
  a_r6_tpr_only_on_store: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready && req_write) |=> $stable(tpr_value));
endmodule

bind intack_bridge intack_bridge_chk chk_i (.*);

// File: tb/intack_bridge_tb_top.sv
`timescale 1ns/1ps
module intack_bridge_tb_top;
  localparam int P = 2;
  localparam int G = 1;
  localparam logic [31:0] BASE = 32'hFE00_0000;
  localparam logic [31:0] ACK_A = BASE + 32'h001E_0000;
  localparam logic [31:0] TPR_A = BASE + 32'h001E_0008;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b0, dbl_mode = 1'b0;
  logic [31:0] req_addr = '0;
  logic [1:0] req_size = '0;
  logic [7:0] req_wdata = '0;
  logic req_ready, rsp_valid, rsp_err, ack_strobe, tpr_update, undef_flag;
  logic [7:0] rsp_data, tpr_value, ctl_vector;

  logic [7:0] cur_vec = 8'h00;
  int pulses_seen = 0;
  int n_checks = 0;
  int n_errors = 0;
  logic [7:0] model_tpr = 8'h00;
  logic model_undef = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge ack_strobe) pulses_seen = pulses_seen + 1;
  assign ctl_vector = !ack_strobe ? 8'hC3 :
                      (dbl_mode && pulses_seen == 1) ? ~cur_vec : cur_vec;

  intack_bridge #(.ADDR_W(32), .BASE(BASE), .TPR_OFS(32'h001E_0008),
                  .PULSE_CLKS(P), .GAP_CLKS(G)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .dbl_mode(dbl_mode),
    .ack_strobe(ack_strobe), .ctl_vector(ctl_vector), .tpr_value(tpr_value),
    .tpr_update(tpr_update), .undef_flag(undef_flag)
  );

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One access: drive, wait for response, check timing, data, side effects, back-pressure.
  task automatic access(input logic [31:0] a, input logic wr, input logic [1:0] sz,
                        input logic [7:0] wd, input logic dbl, input logic [7:0] vec);
    logic is_ack, is_undef, is_tpr_wr;
    int exp_lat, exp_high, exp_pulses, lat, high, rises;
    logic prev;
    logic [7:0] exp_data;
    is_ack    = (a == ACK_A) && !wr && (sz == 2'd0);
    is_undef  = (a == ACK_A) && !is_ack;
    is_tpr_wr = (a == TPR_A) && wr && (sz == 2'd0);
    exp_lat    = is_ack ? (dbl ? 2*P + G + 1 : P + 1) : 1;
    exp_high   = is_ack ? (dbl ? 2*P : P) : 0;
    exp_pulses = is_ack ? (dbl ? 2 : 1) : 0;
    exp_data   = is_ack ? vec : 8'h00;
    if (is_tpr_wr) model_tpr = wd;
    if (is_undef) model_undef = 1'b1;

    @(negedge clk);
    cur_vec = vec; pulses_seen = 0; dbl_mode = dbl; rsp_ready = 1'b0;
    check("R7 ready when idle", req_ready, 1);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_size = sz; req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    // R6: register and pulse visible in the first cycle after acceptance
    check("R6 tpr value", tpr_value, model_tpr);
    check("R6 tpr pulse", tpr_update, is_tpr_wr);
    lat = 1; high = 0; rises = 0; prev = 1'b0;
    while (!rsp_valid && lat < 50) begin
      if (req_ready) check("R7 ready low while busy", 1, 0);
      if (ack_strobe) high++;
      if (ack_strobe && !prev) rises++;
      prev = ack_strobe;
      @(negedge clk);
      lat++;
    end
    if (is_ack) begin
      check(dbl ? "R4 latency" : "R3 latency", lat, exp_lat);
      check(dbl ? "R4 strobe cycles" : "R3 strobe cycles", high, exp_high);
      check(dbl ? "R4 pulses" : "R3 pulses", rises, exp_pulses);
      check(dbl ? "R4 vector" : "R3 vector", rsp_data, exp_data);
      check("R2 ack err", rsp_err, 0);
    end else if (is_undef) begin
      check("R5 latency", lat, exp_lat);
      check("R5 no strobe", high, 0);
      check("R5 err", rsp_err, 1);
      check("R5 data zero", rsp_data, 0);
      check("R5 sticky flag", undef_flag, 1);
    end else begin
      check("R9 latency", lat, exp_lat);
      check("R9 no strobe", high, 0);
      check("R9 data zero", rsp_data, 0);
      check("R9 err clear", rsp_err, 0);
      check("R6 tpr after access", tpr_value, model_tpr);
      check("R5 flag unchanged", undef_flag, model_undef);
    end
    repeat (2) begin
      @(negedge clk);
      check("R8 held valid", rsp_valid, 1);
      check("R8 held data", rsp_data, exp_data);
      check("R8 held err", rsp_err, is_undef);
      check("R7 ready low while rsp", req_ready, 0);
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    check("R8 valid drops", rsp_valid, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 ready", req_ready, 1);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 strobe", ack_strobe, 0);
    check("R1 tpr_update", tpr_update, 0);
    check("R1 undef_flag", undef_flag, 0);
    check("R1 tpr_value", tpr_value, 0);

    // R2/R3/R4: full vector sweep in both modes
    for (int m = 0; m < 2; m++)
      for (int v = 0; v < 256; v++)
        access(ACK_A, 1'b0, 2'd0, 8'h00, m[0], v[7:0]);

    // R9: neighbouring and unrelated addresses
    access(ACK_A + 32'd1, 1'b0, 2'd0, 8'h00, 1'b0, 8'h11);
    access(ACK_A - 32'd1, 1'b0, 2'd0, 8'h00, 1'b1, 8'h12);
    access(BASE, 1'b0, 2'd0, 8'h00, 1'b0, 8'h13);
    access(32'h0000_0000, 1'b1, 2'd0, 8'h44, 1'b0, 8'h14);

    // R6: task-priority sweep over sizes, directions and values
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 2; w++)
        for (int d = 0; d < 8; d++)
          access(TPR_A, w[0], s[1:0], 8'(d * 37 + s * 5 + 1), 1'b0, 8'h00);

    // R5: every undefined access type to the acknowledge byte, both modes
    for (int m = 0; m < 2; m++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 2; w++)
          if (!(w == 0 && s == 0)) access(ACK_A, w[0], s[1:0], 8'h5A, m[0], 8'h77);

    // R3/R4 after undefined accesses: still functional
    access(ACK_A, 1'b0, 2'd0, 8'h00, 1'b1, 8'hA5);
    access(ACK_A, 1'b0, 2'd0, 8'h00, 1'b0, 8'h3C);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule